// File: doc/BRIEF.md
# Collision Backoff Delay Generator

This block times the pause a 10 Mb/s Ethernet MAC takes before it retries a frame after a collision. The MAC pulses a start strobe and supplies the retry attempt number. It also supplies a choice between two exponent rules and a control that skips the random part entirely. The block draws a random slot count from a range of 2^k values, where k follows from the attempt number and the chosen rule. It counts out that many slot times and then the interframe gap, and then pulses a done flag for one cycle.

A 16-bit maximal-length linear feedback shift register advances on every clock. Its low bits, masked down to k bits, give the slot count. The count drawn is presented on an output and held until the next start, so the MAC, or a bench, can see which wait is in progress. One slot is 512 bit clocks and the gap is 96 bit clocks by default. Both are parameters.

Top module: `backoff_delay_gen`

## Requirements
- R1: After reset, and while reset is held, busy_o is 0, done_o is 0 and slots_o is 0.
- R2: With modified_i = 0 and disable_i = 0, the exponent is k = min(attempt_i, 10), and the slot count shown on slots_o after a start is below 2^k. An attempt of 0 therefore gives 0 slots.
- R3: With modified_i = 1 and disable_i = 0, the exponent is 3 for attempt_i of 0, 1 or 2, and min(attempt_i, 10) otherwise. Attempts below 3 therefore draw from 0 to 7.
- R4: With disable_i = 1 at the start strobe, slots_o is 0 and done_o follows after exactly the gap length, whatever attempt_i and modified_i are.
- R5: Take the clock edge that samples start_i high as edge 0. done_o is 1 in the cycle after edge r*SLOT_CYCLES + IFG_CYCLES, where r is the value on slots_o.
- R6: done_o is high for exactly one cycle. busy_o is 1 from the edge that samples the start until the edge that raises done_o, and busy_o is 0 while done_o is 1.
- R7: A start strobe that arrives while busy_o is 1 draws a new count from the new inputs. Timing then restarts from that strobe, and the earlier wait produces no done.
- R8: The random value changes from draw to draw. Repeated draws with k = 10 give more than one value, and some of them are 8 or larger.
- R9: slots_o keeps its value after done_o until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a backoff wait |
| attempt_i | input | ATT_W (5) | Retransmission attempt number n |
| modified_i | input | 1 | 1 selects the modified exponent rule |
| disable_i | input | 1 | 1 skips the random wait, gap only |
| busy_o | output | 1 | Wait in progress |
| done_o | output | 1 | One-cycle pulse at the end of the wait |
| slots_o | output | MAX_EXP (10) | Slot count drawn for the current or last wait |

## Verification
The bench goes after the exponent edges: attempt 0, the step from 2 to 3 under the modified rule, 10, and counts above 10. A wrong clamp there would let slots_o exceed its bound, or would keep it stuck below 2, below 8 or below 1024. Each wait is timed to the exact cycle from slots_o. This catches a counter that is off by one slot or one cycle, and a gap that is skipped when r is 0. Restarts in the middle of a wait, disable combined with large attempts, and reset during a wait are each driven. A design that finished the old wait, drew a random count under disable, or kept busy_o through reset would miss the expected done cycle or state.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SLOT = 2'd1,
        PH_GAP  = 2'd2
    } phase_e;

endpackage

// File: rtl/backoff_lfsr.sv
module backoff_lfsr #(
    parameter int              LFSR_W = 16,
    parameter logic [15:0]     SEED   = 16'hACE1,
    parameter int              OUT_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rand_o
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;
    logic              feedback;

    // taps for x^16 + x^14 + x^13 + x^11 + 1
    always_comb begin
        feedback = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
        lfsr_d   = {lfsr_q[LFSR_W-2:0], feedback};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rand_o = lfsr_q[OUT_W-1:0];

    // R8: a maximal-length register never falls into the all-zero lock state
    assert_lfsr_alive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/backoff_exp_sel.sv
module backoff_exp_sel #(
    parameter int ATT_W     = 5,
    parameter int MAX_EXP   = 10,
    parameter int MOD_FLOOR = 3,
    parameter int EXP_W     = 4
) (
    input  logic [ATT_W-1:0] attempt_i,
    input  logic             modified_i,
    output logic [EXP_W-1:0] exp_o
);
    logic [ATT_W-1:0] clamped;

    always_comb begin
        if (attempt_i > ATT_W'(MAX_EXP)) clamped = ATT_W'(MAX_EXP);
        else                             clamped = attempt_i;
        if (modified_i && (attempt_i < ATT_W'(MOD_FLOOR)))
            clamped = ATT_W'(MOD_FLOOR);
        exp_o = EXP_W'(clamped);
    end

endmodule

// File: rtl/backoff_range_mask.sv
module backoff_range_mask #(
    parameter int R_W   = 10,
    parameter int EXP_W = 4
) (
    input  logic [R_W-1:0]   rand_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic [R_W-1:0]   r_o
);
    for (genvar i = 0; i < R_W; i++) begin : g_bit
        assign r_o[i] = rand_i[i] & (exp_i > EXP_W'(i));
    end

endmodule

// File: rtl/backoff_timer.sv
module backoff_timer
    import backoff_pkg::*;
#(
    parameter int SLOT_CYCLES = 512,
    parameter int IFG_CYCLES  = 96,
    parameter int R_W         = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           disable_i,
    input  logic [R_W-1:0] r_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [R_W-1:0] slots_o
);
    localparam int CNT_MAX = (SLOT_CYCLES > IFG_CYCLES) ? SLOT_CYCLES : IFG_CYCLES;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CYCLES - 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(IFG_CYCLES - 1);

    typedef struct packed {
        phase_e         phase;
        logic [R_W-1:0] left;
        logic [CNT_W-1:0] cnt;
        logic [R_W-1:0] slots;
        logic           done;
    } tstate_t;

    tstate_t st_d, st_q;
    logic [R_W-1:0] r_eff;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        r_eff     = disable_i ? '0 : r_i;

        case (st_q.phase)
            PH_SLOT: begin
                if (st_q.cnt == '0) begin
                    if (st_q.left == R_W'(1)) begin
                        st_d.phase = PH_GAP;
                        st_d.cnt   = GAP_LAST;
                    end else begin
                        st_d.left = st_q.left - R_W'(1);
                        st_d.cnt  = SLOT_LAST;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_GAP: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: ;
        endcase

        if (start_i) begin
            st_d.slots = r_eff;
            st_d.left  = r_eff;
            st_d.done  = 1'b0;
            if (r_eff == '0) begin
                st_d.phase = PH_GAP;
                st_d.cnt   = GAP_LAST;
            end else begin
                st_d.phase = PH_SLOT;
                st_d.cnt   = SLOT_LAST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, left: '0, cnt: '0, slots: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.phase != PH_IDLE);
    assign done_o  = st_q.done;
    assign slots_o = st_q.slots;

    // R6: done lasts one cycle and never overlaps a running wait
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R7: a start always (re)opens a wait, even mid-wait
    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !done_o));
    // R4: disable forces a zero draw
    assert_disable_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && disable_i) |=> (slots_o == '0));
    // R9: the drawn count is only replaced by a start
    assert_slots_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(slots_o));
    // R5: the gap phase is never skipped on the way to done
    assert_gap_before_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SLOT && !start_i) |=> !done_o);

endmodule

// File: rtl/backoff_delay_gen.sv
module backoff_delay_gen #(
    parameter int          ATT_W       = 5,
    parameter int          MAX_EXP     = 10,
    parameter int          MOD_FLOOR   = 3,
    parameter int          SLOT_CYCLES = 512,
    parameter int          IFG_CYCLES  = 96,
    parameter int          LFSR_W      = 16,
    parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ATT_W-1:0]   attempt_i,
    input  logic               modified_i,
    input  logic               disable_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [MAX_EXP-1:0] slots_o
);
    localparam int R_W   = MAX_EXP;
    localparam int EXP_W = $clog2(MAX_EXP + 1);

    logic [R_W-1:0]   rand_w;
    logic [EXP_W-1:0] exp_w;
    logic [R_W-1:0]   r_w;

    backoff_lfsr #(
        .LFSR_W (LFSR_W),
        .SEED   (LFSR_SEED),
        .OUT_W  (R_W)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rand_o (rand_w)
    );

    backoff_exp_sel #(
        .ATT_W     (ATT_W),
        .MAX_EXP   (MAX_EXP),
        .MOD_FLOOR (MOD_FLOOR),
        .EXP_W     (EXP_W)
    ) u_exp (
        .attempt_i  (attempt_i),
        .modified_i (modified_i),
        .exp_o      (exp_w)
    );

    backoff_range_mask #(
        .R_W   (R_W),
        .EXP_W (EXP_W)
    ) u_mask (
        .rand_i (rand_w),
        .exp_i  (exp_w),
        .r_o    (r_w)
    );

    backoff_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .IFG_CYCLES  (IFG_CYCLES),
        .R_W         (R_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .disable_i (disable_i),
        .r_i       (r_w),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .slots_o   (slots_o)
    );

    // R2: standard rule follows the attempt number up to the cap
    assert_std_exp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!modified_i && attempt_i <= ATT_W'(MAX_EXP)) |-> (exp_w == EXP_W'(attempt_i)));
    // R3: modified rule floors the exponent for early retries
    assert_mod_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (modified_i && attempt_i < ATT_W'(MOD_FLOOR)) |-> (exp_w == EXP_W'(MOD_FLOOR)));
    // R2: exponent never exceeds the cap
    assert_exp_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exp_w <= EXP_W'(MAX_EXP));
    // R2: the drawn count fits in k bits
    assert_draw_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ((slots_o >> $past(exp_w)) == '0));

endmodule

// File: tb/backoff_delay_gen_test.sv
`timescale 1ns/1ps
module backoff_delay_gen_test;
    localparam int SLOT = 8;
    localparam int IFG  = 6;
    localparam int NV   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] attempt = '0;
    logic       modified = 1'b0;
    logic       disable_bo = 1'b0;
    logic       busy, done;
    logic [9:0] slots;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    backoff_delay_gen #(
        .SLOT_CYCLES (SLOT),
        .IFG_CYCLES  (IFG)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .attempt_i  (attempt),
        .modified_i (modified),
        .disable_i  (disable_bo),
        .busy_o     (busy),
        .done_o     (done),
        .slots_o    (slots)
    );

    // columns: attempt, modified, disable, exclusive bound 2^k
    localparam int VEC [NV][4] = '{
        '{0, 0, 0, 1},    '{1, 0, 0, 2},   '{2, 0, 0, 4},   '{3, 0, 0, 8},
        '{5, 0, 0, 32},   '{10, 0, 0, 1024}, '{15, 0, 0, 1024}, '{31, 0, 0, 1024},
        '{0, 1, 0, 8},    '{1, 1, 0, 8},   '{2, 1, 0, 8},   '{3, 1, 0, 8},
        '{4, 1, 0, 16},   '{12, 1, 0, 1024}, '{7, 0, 1, 1},  '{0, 1, 1, 1}
    };

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_start(input int att, input bit m, input bit d);
        @(negedge clk);
        start = 1'b1; attempt = 5'(att); modified = m; disable_bo = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    // counts cycles from the start edge; also reports busy dropping early
    task automatic wait_done(output int c, output bit busy_ok);
        c = 0; busy_ok = 1'b1;
        do begin
            @(negedge clk);
            c++;
            if (!done && !busy) busy_ok = 1'b0;
            if (done && busy) busy_ok = 1'b0;
        end while (!done && c < 20000);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected done earlier", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c, s, mx, distinct, first;
        bit bok;

        repeat (3) @(negedge clk);
        chk("R1", int'(busy), 0, "busy in reset");
        chk("R1", int'(done), 0, "done in reset");
        chk("R1", int'(slots), 0, "slots in reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_start(VEC[i][0], VEC[i][1] != 0, VEC[i][2] != 0);
            s = int'(slots);
            chk((VEC[i][1] != 0) ? "R3" : "R2", int'(s < VEC[i][3]), 1, "slots below 2^k");
            if (VEC[i][2] != 0) chk("R4", s, 0, "slots under disable");
            chk("R6", int'(busy), 1, "busy after start");
            wait_done(c, bok);
            chk("R5", c, s * SLOT + IFG, "cycles to done");
            chk("R6", int'(bok), 1, "busy span");
            @(negedge clk);
            chk("R6", int'(done), 0, "done width");
            repeat (2) @(negedge clk);
            chk("R9", int'(slots), s, "slots held");
        end

        // R4 with a large attempt and modified rule
        do_start(10, 1'b1, 1'b1);
        chk("R4", int'(slots), 0, "disable large attempt");
        wait_done(c, bok);
        chk("R4", c, IFG, "gap only");

        // R7 restart mid-wait
        do_start(10, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        do_start(0, 1'b0, 1'b0);
        chk("R7", int'(slots), 0, "restart draws new count");
        wait_done(c, bok);
        chk("R7", c, IFG, "restart timing");
        repeat (SLOT * 4) @(negedge clk);
        chk("R7", int'(done), 0, "no late done from old wait");

        // R8 spread of draws at k = 10
        mx = 0; distinct = 0; first = -1;
        for (int i = 0; i < 12; i++) begin
            do_start(10, 1'b0, 1'b0);
            s = int'(slots);
            if (first < 0) first = s;
            else if (s != first) distinct++;
            if (s > mx) mx = s;
        end
        wait_done(c, bok);
        chk("R8", int'(distinct > 0), 1, "draws vary");
        chk("R8", int'(mx >= 8), 1, "draw reaches 8 or above");

        // R3 modified attempt 1 spreads to 0..7
        mx = 0;
        for (int i = 0; i < 12; i++) begin
            do_start(1, 1'b1, 1'b0);
            s = int'(slots);
            if (s > mx) mx = s;
        end
        chk("R3", int'(mx >= 2), 1, "modified floor widens range");
        chk("R3", int'(mx < 8), 1, "modified floor bound");
        wait_done(c, bok);

        // R1 reset during a wait
        do_start(3, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", int'(busy), 0, "busy after mid reset");
        chk("R1", int'(slots), 0, "slots after mid reset");
        chk("R1", int'(done), 0, "done after mid reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule